// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a parallel NOR-style memory, built in synthesizable logic over a small internal word array. The host drives a chip-enable, write-enable and output-enable bus. A write does not land in the array directly. Short write sequences, each opened by two fixed unlock cycles, select one of three behaviours: plain array reads, an identification view, or a single-word program operation.

In the identification view, reads return a manufacturer code, a device code and a protection flag for each sector. The device code is read in an 8-bit or a 16-bit format. A program operation captures one address and one data word, then stays busy for a parameterised number of clock cycles. During that time the host polls bit 7 of the target word: the bit reads inverted until the program finishes. The controller then goes back to plain reads by itself. All bus inputs are sampled on the system clock.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode and is not busy, and every array word reads 16'hFFFF. A reset asserted during a program operation abandons that operation.
- R2: In array-read mode, a cycle with ce_n and oe_n both low returns the word at index addr[ARR_AW-1:0] on dq_out one clock later. A cycle without that read returns 0. The mode persists until a command sequence changes it.
- R3: The sequence AAh@555h, 55h@2AAh, 90h@555h enters ID mode. Commands are compared on dq_in[7:0] and addr[10:0]. In ID mode, addr[7:0]=00h reads 16'h00AD. addr[7:0]=01h reads DEV_ID when wide=1, or {8'h00, DEV_ID[7:0]} when wide=0.
- R4: The low byte of every ID code has odd parity, with bit 7 as the parity bit.
- R5: In ID mode, an address other than 00h/01h with addr[6]=0 and addr[1:0]=2'b10 reads 16'h0001 if the sector addr[11:10] is marked in PROT_MASK, and 16'h0000 if it is not. Other ID addresses read 0.
- R6: ID mode is left only by the sequence AAh@555h, 55h@2AAh, F0h@555h. Stray writes in ID mode leave it in ID mode.
- R7: The sequence AAh@555h, 55h@2AAh, A0h@555h followed by one write programs that write's address. The new word is the old word AND the written data.
- R8: The program address is the one present when both ce_n and we_n are first low together. The program data is the one present on the first cycle in which either strobe has returned high.
- R9: While the program operation runs, a read at the target index returns bit 7 equal to the inverse of the written bit 7, with all other bits 0. A read at any other index returns 0.
- R10: The program operation stays busy for exactly PROG_CYCLES clock cycles, starting on the edge that captures the data. During that time every write is ignored. Afterwards the block is in array-read mode.
- R11: A write that does not continue a valid sequence restarts sequence decoding and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| wide | input | 1 | 1 selects the 16-bit device-code format |
| addr | input | ADDR_W | Bus address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Registered read data, 0 when no read is active |

## Verification
Every read result appears one clock after the edge that samples ce_n, oe_n and addr. The scoreboard therefore marks each read at that edge and compares it on the following falling edge. A command or program write takes effect on the edge after its strobe returns high. The first read after a program sequence is sampled on the first busy cycle. Reads placed PROG_CYCLES-1 and PROG_CYCLES idle cycles later land on the last busy cycle and the first idle cycle, which tests the busy window to the exact cycle.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W = 12,
  parameter int ARR_AW = 6,
  parameter int SECT_W = 2,
  parameter logic [7:0] MFR_ID = 8'hAD,
  parameter logic [15:0] DEV_ID = 16'h2223,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b0101,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out
);
  localparam int DEPTH = 1 << ARR_AW;
  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_UNL1, S_UNL2, S_PGM} seq_t;

  logic [15:0]       mem [DEPTH];
  logic              wr_q;
  logic [10:0]       a_lat;
  seq_t              seq;
  logic              id_mode;
  logic              busy;
  logic [CW-1:0]     cnt;
  logic [ARR_AW-1:0] tgt;
  logic [15:0]       pd;
  logic [15:0]       rd_val;

  wire              wr_now   = ~ce_n & ~we_n;
  wire              wr_start = wr_now & ~wr_q;
  wire              wr_end   = ~wr_now & wr_q;
  wire [7:0]        cd       = dq_in[7:0];
  wire [SECT_W-1:0] sect     = addr[ADDR_W-1 -: SECT_W];
  wire [ARR_AW-1:0] idx      = addr[ARR_AW-1:0];

  always_comb begin
    rd_val = 16'h0000;
    if (busy) begin
      if (idx == tgt) rd_val = {8'h00, ~pd[7], 7'h00};
    end else if (id_mode) begin
      if (addr[7:0] == 8'h00)
        rd_val = {8'h00, MFR_ID};
      else if (addr[7:0] == 8'h01)
        rd_val = wide ? DEV_ID : {8'h00, DEV_ID[7:0]};
      else if (!addr[6] && addr[1:0] == 2'b10)
        rd_val = {15'h0000, PROT_MASK[sect]};
    end else begin
      rd_val = mem[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      a_lat   <= '0;
      seq     <= S_IDLE;
      id_mode <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      tgt     <= '0;
      pd      <= '0;
      dq_out  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      wr_q   <= wr_now;
      dq_out <= (~ce_n & ~oe_n) ? rd_val : 16'h0000;
      if (wr_start) a_lat <= addr[10:0];
      if (busy) begin
        if (cnt == '0) begin
          busy     <= 1'b0;
          mem[tgt] <= mem[tgt] & pd;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (wr_end) begin
        case (seq)
          S_IDLE: seq <= (a_lat == 11'h555 && cd == 8'hAA) ? S_UNL1 : S_IDLE;
          S_UNL1: seq <= (a_lat == 11'h2AA && cd == 8'h55) ? S_UNL2 : S_IDLE;
          S_UNL2: begin
            seq <= S_IDLE;
            if (a_lat == 11'h555) begin
              case (cd)
                8'h90:   id_mode <= 1'b1;
                8'hF0:   id_mode <= 1'b0;
                8'hA0:   seq <= S_PGM;
                default: ;
              endcase
            end
          end
          default: begin
            seq     <= S_IDLE;
            busy    <= 1'b1;
            cnt     <= CW'(PROG_CYCLES - 1);
            tgt     <= a_lat[ARR_AW-1:0];
            pd      <= dq_in;
            id_mode <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ARR_AW = 6,
  parameter int PROG_CYCLES = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic [7:0]        a_lo,
  input logic [7:0]        q_lo,
  input logic              busy,
  input logic              id_mode,
  input logic [ARR_AW-1:0] tgt,
  input logic              pd7
);
  int bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= busy ? bcnt + 1 : 0;
  end

  a_r4_id_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && !busy && !ce_n && !oe_n && a_lo[7:1] == 7'h00) |=> (^q_lo));

  a_r9_poll_dq7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ce_n && !oe_n && a_lo[ARR_AW-1:0] == tgt) |=> (q_lo[7] != $past(pd7)));

  a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == PROG_CYCLES));

  a_r10_no_id_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !id_mode);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ARR_AW(ARR_AW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .a_lo(addr[7:0]), .q_lo(dq_out[7:0]), .busy(busy), .id_mode(id_mode),
  .tgt(tgt), .pd7(pd[7])
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int PC = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wide = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wide(wide), .addr(addr), .dq_in(dq_in), .dq_out(dq_out)
  );

  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_mark = 1'b0, chk_due = 1'b0;

  always @(posedge clk) chk_due <= rd_mark & ~ce_n & ~oe_n;

  always @(negedge clk) begin
    if (chk_due) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty act=%h exp=none", dq_out);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dq_out !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, dq_out, e);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; rd_mark = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; rd_mark = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
    wr(12'h555, {8'h00, c});
  endtask

  task automatic prog(input logic [11:0] a, input logic [15:0] d);
    cmd(8'hA0);
    wr(a, d);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h005, 16'hFFFF, "R1 erased after reset");

    prog(12'h005, 16'h1234);
    rd(12'h005, 16'h0080, "R9 poll inverted dq7");
    rd(12'h006, 16'h0000, "R9 other index while busy");
    repeat (PC) @(negedge clk);
    rd(12'h005, 16'h1234, "R7 programmed word");
    rd(12'h005, 16'h1234, "R2 read mode persists");

    prog(12'h005, 16'hFF0F);
    repeat (PC - 1) @(negedge clk);
    rd(12'h005, 16'h0080, "R10 last busy cycle");
    rd(12'h005, 16'h1204, "R7 AND with old word");

    prog(12'h008, 16'h5A5A);
    repeat (PC) @(negedge clk);
    rd(12'h008, 16'h5A5A, "R10 first idle cycle");

    cmd(8'h90);
    rd(12'h000, 16'h00AD, "R3 manufacturer code");
    rd(12'h001, 16'h0023, "R3 device code byte format");
    wide = 1'b1;
    rd(12'h001, 16'h2223, "R3 device code word format");
    wide = 1'b0;
    rd(12'h301, 16'h0023, "R4 odd-parity code, high address ignored");
    rd(12'h002, 16'h0001, "R5 sector0 protected");
    rd(12'h402, 16'h0000, "R5 sector1 open");
    rd(12'h802, 16'h0001, "R5 sector2 protected");
    rd(12'h842, 16'h0000, "R5 A6 set reads zero");

    wr(12'h100, 16'h0012);
    rd(12'h000, 16'h00AD, "R6 stray write keeps ID");
    wr(12'h555, 16'h00F0);
    rd(12'h000, 16'h00AD, "R6 lone F0 keeps ID");
    cmd(8'hF0);
    rd(12'h005, 16'h1204, "R6 reset sequence exits ID");

    wr(12'h555, 16'h00AA);
    wr(12'h123, 16'h0055);
    wr(12'h005, 16'h0000);
    rd(12'h005, 16'h1204, "R11 broken sequence no store");

    cmd(8'hA0);
    @(negedge clk); addr = 12'h003; dq_in = 16'h0000; ce_n = 1'b0;
    @(negedge clk); addr = 12'h009; dq_in = 16'h0F0F; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; addr = 12'h003; dq_in = 16'h0000;
    repeat (PC + 2) @(negedge clk);
    rd(12'h009, 16'h0F0F, "R8 address at later falling strobe");
    rd(12'h003, 16'hFFFF, "R8 early address not used");

    prog(12'h00A, 16'h00FF);
    cmd(8'h90);
    repeat (PC) @(negedge clk);
    rd(12'h00A, 16'h00FF, "R10 done returns to read mode");
    rd(12'h000, 16'hFFFF, "R10 ID sequence ignored while busy");

    prog(12'h011, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h011, 16'hFFFF, "R1 reset abandons program");
    rd(12'h000, 16'hFFFF, "R1 read mode after reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R2 pending reads act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule